// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the front end of a DMA engine. It carries one transfer across a chain of buffer descriptors held in memory. Software programs a list base address plus the link word, buffer address and buffer length of the first descriptor. It then writes the control register. The walker hands each buffer to a data-path engine as an address/length pair and waits for that engine to report the buffer finished. It then follows the chain. It reads the next three-word descriptor from memory at the list base plus the byte offset held in the current link word.

Each descriptor is stored as three consecutive 32-bit words: link, buffer address, buffer length. The link word packs a 16-bit byte offset with three flags. The chain ends at the first descriptor whose continue flag is clear. After the final buffer the walker pulses `done`. If a buffer breaks its alignment rules the walker pulses `err` instead, and that buffer is never presented.

The controller moves through six named states. **IDLE** waits for a start. On a start it goes to **CHECK**, which validates the loaded buffer. CHECK goes to **STREAM** when the buffer is legal and to **ERR** when it is not. STREAM presents the buffer. When the buffer finishes, STREAM goes to **FETCH** if the chain continues and to **DONE** if it ends or a stop was requested. FETCH reads three words and then returns to CHECK. DONE and ERR each last one cycle and return to IDLE.

Top module: `llist_dma_walker`

## Requirements
- R1: After reset the walker is idle: `buf_valid`, `done`, `err` and `mem_req` are all low.
- R2: Start is requested by writing the control register (address 0) with bit 0 (DMA enable) set while idle. With bit 1 (list enable) also set, the first buffer is presented from the programmed address (reg 3) and length (reg 4), and no memory read is made for it.
- R3: If only bit 0 is set, exactly one buffer is presented from regs 3/4 with `buf_last` high. The programmed link word is ignored and no memory read is made.
- R4: When a non-final buffer finishes, the walker reads the words at list base (reg 1) plus offset, +4 and +8, in that order. It keeps at most one read outstanding and never reads while a buffer is presented.
- R5: Link word layout: bits [15:0] hold the byte offset of the next descriptor, bit 31 is continue, and bit 30 is update-length. When bit 30 of a fetched link is clear, the fetched length word is discarded and the previous length is kept. Bit 29 (buffer-ready) has no effect on the walk.
- R6: A buffer whose link has bit 31 clear is the last one. It is presented with `buf_last` high, and `done` pulses once after its `buf_done`.
- R7: While `buf_valid` is high and `buf_done` is low, `buf_addr`, `buf_len` and `buf_valid` hold.
- R8: A buffer whose address bits [1:0] are not zero is not presented. `err` pulses and the walker returns to idle.
- R9: A non-last buffer whose length is not a multiple of BURST_BYTES (16) raises `err` in the same way. A last buffer has no length constraint.
- R10: Writing control with bit 0 clear while active lets the current buffer complete. The walker then pulses `done` without fetching further descriptors.
- R11: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | 0 control, 1 list base, 2 link, 3 buffer address, 4 buffer length |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Descriptor word read request (one cycle) |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | A buffer is presented to the data path |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 32 | Buffer length in bytes |
| buf_last | output | 1 | Presented buffer is the final one |
| buf_done | input | 1 | Data path finished the presented buffer |
| done | output | 1 | Transfer-complete pulse |
| err | output | 1 | Alignment-violation pulse |

## Verification
A control write captured at an edge puts the walker in CHECK. The buffer appears two edges after the write, and `err` appears instead at the same point when the buffer is illegal. A `buf_done` sampled at an edge yields `done` one edge later, or the first read request one edge later. With one-cycle memory latency a fetch takes six cycles before CHECK. The bench does not count fixed delays. It samples at falling edges and polls each expected event within a bounded window, and it checks the ordering: no buffer after `err` or `done`, and no read outside the expected list.

// File: rtl/llw_pkg.sv
package llw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_STREAM,
        S_FETCH,
        S_DONE,
        S_ERR
    } walk_state_t;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_LBASE = 3'd1;
    localparam logic [2:0] RA_LINK  = 3'd2;
    localparam logic [2:0] RA_BADDR = 3'd3;
    localparam logic [2:0] RA_BLEN  = 3'd4;

    localparam int LNK_CONT_BIT = 31;
    localparam int LNK_ULEN_BIT = 30;
    localparam int LNK_OFF_W    = 16;
endpackage

// File: rtl/llw_align_chk.sv
module llw_align_chk #(
    parameter int BURST_LSB = 4
) (
    input  logic [1:0]           addr_lo,
    input  logic [BURST_LSB-1:0] len_lo,
    input  logic                 is_last,
    output logic                 bad
);
    logic addr_bad;
    logic len_bad;

    assign addr_bad = (addr_lo != 2'b00);
    assign len_bad  = !is_last && (len_lo != '0);
    assign bad      = addr_bad || len_bad;
endmodule

// File: rtl/llw_desc_fetch.sv
module llw_desc_fetch #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      desc_addr,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_rvalid,
    input  logic [DW-1:0]      mem_rdata,
    output logic [2:0][DW-1:0] words,
    output logic               fin
);
    logic          busy;
    logic          waiting;
    logic [1:0]    idx;
    logic [AW-1:0] base_q;

    assign mem_req  = busy && !waiting;
    assign mem_addr = base_q + AW'({idx, 2'b00});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            waiting <= 1'b0;
            idx     <= '0;
            base_q  <= '0;
            words   <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                waiting <= 1'b0;
                idx     <= '0;
                base_q  <= desc_addr;
            end else if (mem_req) begin
                waiting <= 1'b1;
            end else if (waiting && mem_rvalid) begin
                waiting <= 1'b0;
                unique case (idx)
                    2'd0:    words[0] <= mem_rdata;
                    2'd1:    words[1] <= mem_rdata;
                    default: words[2] <= mem_rdata;
                endcase
                if (idx == 2'd2) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    idx <= idx + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/llist_dma_walker.sv
module llist_dma_walker #(
    parameter int AW          = 32,
    parameter int BURST_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          buf_valid,
    output logic [AW-1:0] buf_addr,
    output logic [31:0]   buf_len,
    output logic          buf_last,
    input  logic          buf_done,
    output logic          done,
    output logic          err
);
    import llw_pkg::*;

    localparam int BURST_LSB = $clog2(BURST_BYTES);

    walk_state_t state, state_nx;

    logic          ll_mode;
    logic          stop_req;
    logic [AW-1:0] lbase_q;
    logic [31:0]   link_q;
    logic [AW-1:0] addr_q;
    logic [31:0]   len_q;

    logic             is_last;
    logic             bad;
    logic             start_req;
    logic             stop_wr;
    logic             fetch_start;
    logic             fetch_fin;
    logic [2:0][31:0] fetch_words;
    logic [AW-1:0]    next_desc;
    logic             unused_bits;

    assign is_last     = !ll_mode || !link_q[LNK_CONT_BIT];
    assign start_req   = reg_wr_en && (reg_addr == RA_CTRL) && reg_wdata[0] && (state == S_IDLE);
    assign stop_wr     = reg_wr_en && (reg_addr == RA_CTRL) && !reg_wdata[0] && (state != S_IDLE);
    assign fetch_start = (state == S_STREAM) && buf_done && !is_last && !stop_req;
    assign next_desc   = lbase_q + AW'(link_q[LNK_OFF_W-1:0]);
    assign unused_bits = ^{link_q[29:LNK_OFF_W], reg_wdata[31:2]};

    llw_align_chk #(.BURST_LSB(BURST_LSB)) u_chk_align (
        .addr_lo (addr_q[1:0]),
        .len_lo  (len_q[BURST_LSB-1:0]),
        .is_last (is_last),
        .bad     (bad)
    );

    llw_desc_fetch #(.AW(AW), .DW(32)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .desc_addr  (next_desc),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .words      (fetch_words),
        .fin        (fetch_fin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start_req) state_nx = S_CHECK;
            S_CHECK:  state_nx = bad ? S_ERR : S_STREAM;
            S_STREAM: if (buf_done) state_nx = (is_last || stop_req) ? S_DONE : S_FETCH;
            S_FETCH:  if (fetch_fin) state_nx = S_CHECK;
            S_DONE:   state_nx = S_IDLE;
            S_ERR:    state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        buf_valid = (state == S_STREAM);
        buf_addr  = addr_q;
        buf_len   = len_q;
        buf_last  = (state == S_STREAM) && is_last;
        done      = (state == S_DONE);
        err       = (state == S_ERR);
    end

    // descriptor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ll_mode  <= 1'b0;
            stop_req <= 1'b0;
            lbase_q  <= '0;
            link_q   <= '0;
            addr_q   <= '0;
            len_q    <= '0;
        end else begin
            if (state == S_IDLE) stop_req <= 1'b0;
            else if (stop_wr)    stop_req <= 1'b1;
            if (start_req) ll_mode <= reg_wdata[1];
            if (reg_wr_en && state == S_IDLE) begin
                unique case (reg_addr)
                    RA_LBASE: lbase_q <= AW'(reg_wdata);
                    RA_LINK:  link_q  <= reg_wdata;
                    RA_BADDR: addr_q  <= AW'(reg_wdata);
                    RA_BLEN:  len_q   <= reg_wdata;
                    default:  ;
                endcase
            end
            if (fetch_fin) begin
                link_q <= fetch_words[0];
                addr_q <= AW'(fetch_words[1]);
                if (fetch_words[0][LNK_ULEN_BIT]) len_q <= fetch_words[2];
            end
        end
    end
endmodule

// File: rtl/llw_checker.sv
module llw_checker #(
    parameter int AW        = 32,
    parameter int BURST_LSB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          buf_valid,
    input logic [AW-1:0] buf_addr,
    input logic [31:0]   buf_len,
    input logic          buf_last,
    input logic          buf_done,
    input logic          done,
    input logic          err
);
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);                                         // R4
    AST_NO_READ_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> !mem_req);                                       // R4
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !buf_done) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len))); // R7
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> (buf_addr[1:0] == 2'b00));                       // R8
    AST_LEN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !buf_last) |-> (buf_len[BURST_LSB-1:0] == '0));  // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));                                               // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);                                                 // R11
endmodule

bind llist_dma_walker llw_checker #(.AW(AW), .BURST_LSB($clog2(BURST_BYTES))) u_llw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .buf_valid (buf_valid),
    .buf_addr  (buf_addr),
    .buf_len   (buf_len),
    .buf_last  (buf_last),
    .buf_done  (buf_done),
    .done      (done),
    .err       (err)
);

// File: tb/llist_dma_walker_bench.sv
module llist_dma_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        buf_valid;
    logic [31:0] buf_addr;
    logic [31:0] buf_len;
    logic        buf_last;
    logic        buf_done = 1'b0;
    logic        done;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] mem [0:255];
    logic [31:0] exp_fetch [0:15];
    int n_exp_fetch = 0;
    int fetch_cnt = 0;

    always #5 clk = ~clk;

    llist_dma_walker u_llist_dma_walker (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .buf_valid(buf_valid),
        .buf_addr(buf_addr), .buf_len(buf_len), .buf_last(buf_last),
        .buf_done(buf_done), .done(done), .err(err)
    );

    // memory with one cycle latency
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[9:2]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R4 read-order monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mem_req) begin
            if (fetch_cnt < n_exp_fetch)
                chk(mem_addr == exp_fetch[fetch_cnt], "R4 read address", mem_addr, exp_fetch[fetch_cnt]);
            else
                chk(1'b0, "R4 unexpected read", mem_addr, 32'hFFFF_FFFF);
            chk(!buf_valid, "R4 read during stream", {31'b0, buf_valid}, 32'h0);
            fetch_cnt++;
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // outcome: 1 buffer, 2 done, 3 err, 0 nothing
    task automatic wait_evt(output int what);
        what = 0;
        for (int k = 0; k < 40; k++) begin
            if (buf_valid) begin what = 1; return; end
            if (done) begin what = 2; return; end
            if (err) begin what = 3; return; end
            @(negedge clk);
        end
    endtask

    // n descriptors; bad_kind 1 misaligned address, 2 odd length at bad_idx
    task automatic run_case(input int n, input int tag, input bit ll, input int ulen_idx,
                            input int stop_at, input int bad_kind, input int bad_idx);
        logic [31:0] lb, lnk[0:7], ba[0:7], ln[0:7], elen[0:7];
        int npres, nfd, what;
        lb = 32'h100 + 32'(tag % 4) * 32'h40;
        for (int i = 0; i < n; i++) begin
            lnk[i] = 32'((i + 1) * 12) | (32'd1 << 30) | (32'd1 << 29);
            if (i < n - 1) lnk[i] |= 32'd1 << 31;
            if (i == 2) lnk[i] &= ~(32'd1 << 29);   // R5: buffer-ready clear, no effect
            ba[i] = 32'h2000 + 32'(i) * 32'h40 + 32'(tag) * 4;
            ln[i] = (i == n - 1) ? 32'(16 * (tag % 3 + 1) + (tag * 5) % 16) : 32'(16 * (i + 1 + tag % 2));
            elen[i] = ln[i];
            if (i == ulen_idx) begin
                lnk[i] &= ~(32'd1 << 30);
                ln[i] = 32'h3FF;
                elen[i] = elen[i-1];
            end
            if (bad_kind == 1 && i == bad_idx) ba[i] = ba[i] + 2;
            if (bad_kind == 2 && i == bad_idx) begin ln[i] = 32'd20; elen[i] = 32'd20; end
            mem[(lb + 32'(12 * i)) >> 2]     = lnk[i];
            mem[(lb + 32'(12 * i) + 4) >> 2] = ba[i];
            mem[(lb + 32'(12 * i) + 8) >> 2] = ln[i];
        end
        npres = ll ? n : 1;
        if (stop_at >= 0) npres = stop_at + 1;
        if (bad_kind != 0) npres = bad_idx;
        nfd = (bad_kind != 0) ? bad_idx : npres - 1;
        n_exp_fetch = 0;
        fetch_cnt = 0;
        for (int k = 1; k <= nfd; k++)
            for (int w = 0; w < 3; w++) begin
                exp_fetch[n_exp_fetch] = lb + 32'(12 * k + 4 * w);
                n_exp_fetch++;
            end
        wr(3'd1, lb); wr(3'd2, lnk[0]); wr(3'd3, ba[0]); wr(3'd4, ln[0]);
        chk(fetch_cnt == 0, "R2 no read before start", 32'(fetch_cnt), 0);
        wr(3'd0, ll ? 32'd3 : 32'd1);
        for (int p = 0; p < npres; p++) begin
            wait_evt(what);
            chk(what == 1, ll ? "R2/R4 buffer presented" : "R3 single buffer presented", 32'(what), 1);
            if (what != 1) return;
            if (p == 0) chk(fetch_cnt == 0, "R2 first buffer without read", 32'(fetch_cnt), 0);
            chk(buf_addr == ba[p], "R2/R4 buffer address", buf_addr, ba[p]);
            chk(buf_len == elen[p], "R5 buffer length", buf_len, elen[p]);
            chk(buf_last == (!ll || p == n - 1), "R6 last flag", {31'b0, buf_last}, {31'b0, (!ll || p == n - 1)});
            if (p == stop_at) wr(3'd0, 32'd0);
            @(negedge clk);
            chk(buf_valid && buf_addr == ba[p], "R7 buffer held", buf_addr, ba[p]);
            buf_done = 1'b1;
            @(negedge clk);
            buf_done = 1'b0;
        end
        wait_evt(what);
        if (bad_kind != 0)
            chk(what == 3, bad_kind == 1 ? "R8 error on misaligned address" : "R9 error on odd length", 32'(what), 3);
        else
            chk(what == 2, stop_at >= 0 ? "R10 done after stop" : "R6 done after last", 32'(what), 2);
        chk(!(done && err), "R11 exclusive", {30'b0, done, err}, 0);
        @(negedge clk);
        chk(!done && !err, "R11 single pulse", {30'b0, done, err}, 0);
        for (int k = 0; k < 6; k++) begin
            chk(!buf_valid, "R6/R8 no buffer after end", {31'b0, buf_valid}, 0);
            @(negedge clk);
        end
        chk(fetch_cnt == n_exp_fetch, ll ? "R4 read count" : "R3 no reads", 32'(fetch_cnt), 32'(n_exp_fetch));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!buf_valid && !done && !err && !mem_req, "R1 reset idle",
            {28'b0, buf_valid, done, err, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!buf_valid && !done && !err && !mem_req, "R1 idle after reset",
            {28'b0, buf_valid, done, err, mem_req}, 0);
        // chain sweep
        for (int n = 1; n <= 5; n++)
            for (int t = 0; t < 4; t++)
                run_case(n, t, 1'b1, -1, -1, 0, 0);
        // single-buffer mode, link ignored
        for (int t = 0; t < 4; t++) run_case(3, t, 1'b0, -1, -1, 0, 0);
        // update-length clear
        run_case(3, 1, 1'b1, 1, -1, 0, 0);
        run_case(4, 2, 1'b1, 2, -1, 0, 0);
        // stop requests
        run_case(4, 0, 1'b1, -1, 0, 0, 0);
        run_case(4, 3, 1'b1, -1, 2, 0, 0);
        // alignment errors
        run_case(2, 0, 1'b1, -1, -1, 1, 0);
        run_case(3, 1, 1'b1, -1, -1, 1, 2);
        run_case(3, 2, 1'b1, -1, -1, 2, 1);
        run_case(4, 0, 1'b1, -1, -1, 2, 0);
        run_case(1, 1, 1'b0, -1, -1, 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule